// File: doc/BRIEF.md
# Infrared-Capable Asynchronous Serial Port

This block is an asynchronous serial transmitter and receiver. Software pushes bytes into a 64-entry transmit queue. The transmitter takes each byte off the queue, frames it and shifts it out on `txd`. The receiver decodes frames arriving on `rxd` and stores each received byte in a 64-entry receive queue, which software pops. The frame shape is set by static inputs:

- the number of data bits;
- whether a parity bit is sent, and whether it is even or odd;
- one or two stop bits;
- whether the line uses the level-coded form or the pulse-coded infrared form.

Bit timing comes from a prescaler. It counts either every clock or every cycle in which an external enable is high, and it emits one oversampling tick every `divisor+1` counts. Sixteen ticks make one bit. For a wanted baud rate, set `divisor = floor(f_src / (16 * baud)) - 1`. Choose the divisor so that the accumulated timing error over a frame stays below about 1.87 %.

In infrared form, the transmitter marks each zero bit with a high pulse three ticks long and sends nothing for a one bit. The receiver treats any pulse seen inside a bit window as a zero. Parity mismatches, bad stop bits and bytes lost because the receive queue was full each raise a sticky flag. The flags stay set until `err_clr` is pulsed.

Top module: `uart_ir`

## Requirements
- R1: One bit lasts exactly 16 oversampling ticks. A tick occurs once every `divisor+1` source counts. A source count is every clock when `clk_sel`=0, and every clock with `ext_en`=1 when `clk_sel`=1.
- R2: A transmitted frame is sent in this order: one start bit at 0, then 5+`word_len` data bits least significant first (`word_len` 0..3 gives 5..8 bits), then the parity bit if `par_en`=1, then one stop bit at 1, or two if `two_stop`=1.
- R3: The parity bit equals the XOR of the sent data bits when `par_odd`=0 (even parity). It is the inverse of that XOR when `par_odd`=1.
- R4: The transmit queue holds up to 64 bytes. `tx_full` is 1 exactly when 64 bytes wait. A push while `tx_full`=1 is dropped. A byte leaves the queue on the tick that starts its frame.
- R5: With `ir_mode`=1, `txd` is low while idle. Within each bit, a 0 bit drives `txd` high for the first 3 of its 16 ticks and low for the rest; a 1 bit keeps `txd` low.
- R6: With `ir_mode`=0, `txd` is high while idle and carries the frame bit levels directly.
- R7: In level mode the receiver samples each bit at tick 7 of its window, counted from the tick that first sees the start edge. It queues the data bits zero-extended to 8 bits, in arrival order, readable at `rx_data` while `rx_empty`=0.
- R8: In infrared mode the receiver decodes a bit as 0 if a high pulse is seen on `rxd` during that bit window, and as 1 otherwise.
- R9: A received parity bit that disagrees with R3 sets `err_parity`. The byte is still queued. The flag stays set until `err_clr`.
- R10: A received stop bit that decodes as 0 sets `err_frame`. The flag stays set until `err_clr`.
- R11: A frame that completes while the receive queue holds 64 bytes is dropped and sets `err_overrun`. Queued bytes are kept. `err_clr` clears all three flags.
- R12: In level mode, a low on `rxd` that is gone by tick 7 after it was seen is rejected as a start bit. Nothing is queued and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clk_sel | input | 1 | 1: prescaler counts only clocks with `ext_en` high |
| ext_en | input | 1 | Alternate source enable |
| divisor | input | 16 | Prescaler terminal count (tick every divisor+1 counts) |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | Send two stop bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1 |
| ir_mode | input | 1 | Infrared pulse coding |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue holds 64 bytes |
| rx_pop | input | 1 | Remove head of receive queue |
| rx_data | output | 8 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| err_clr | input | 1 | Clear the sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky stop-bit error |
| err_overrun | output | 1 | Sticky receive overflow |

## Verification
The serial output is compared on every clock against a behavioural model of the prescaler and framer. Each case is sent in loopback so that the receiver decodes it too.

The traffic varies along several axes:
- **Bit patterns:** bytes of all zeros, all ones and alternating bits expose bit-order and masking errors.
- **Frame shapes:** the 8-bit, 5-bit with two stops, and 7-bit odd-parity cases separate the data-length, parity-sense and stop-count paths.
- **Tick rates:** tick rates from several divisors, and a gated source, separate tick counting from clock counting.
- **Infrared form:** an infrared run shows whether pulse width and pulse decoding match.

A burst larger than the transmit queue checks both the full flag and the receive overflow. Frames driven by hand with a wrong parity bit, a low stop bit, or only a short low glitch isolate each error flag and the start-bit rejection.

// File: rtl/uart_ir.sv
module uart_ir #(
  parameter int DEPTH = 64,
  parameter int DIVW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_sel,
  input  logic            ext_en,
  input  logic [DIVW-1:0] divisor,
  input  logic [1:0]      word_len,
  input  logic            two_stop,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            ir_mode,
  input  logic            tx_push,
  input  logic [7:0]      tx_data,
  output logic            tx_full,
  input  logic            rx_pop,
  output logic [7:0]      rx_data,
  output logic            rx_empty,
  output logic            txd,
  input  logic            rxd,
  input  logic            err_clr,
  output logic            err_parity,
  output logic            err_frame,
  output logic            err_overrun
);
  // DEPTH must be a power of two: queue pointers wrap naturally.
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // Oversampling tick: one per divisor+1 source counts.
  logic [DIVW-1:0] pre_cnt;
  logic src_en, tick;
  assign src_en = clk_sel ? ext_en : 1'b1;
  assign tick   = src_en && (pre_cnt == divisor);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pre_cnt <= '0;
    else if (src_en) pre_cnt <= tick ? '0 : pre_cnt + DIVW'(1);

  logic [3:0] dbits;
  assign dbits = 4'd5 + {2'b00, word_len};

  // Transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy, tx_wr, tx_load;

  assign tx_full = tx_cnt == CW'(DEPTH);
  assign tx_wr   = tx_push && !tx_full;
  assign tx_load = tick && !tx_busy && tx_cnt != '0;

  always_ff @(posedge clk)
    if (tx_wr) tx_mem[tx_wp] <= tx_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_wr)   tx_wp <= tx_wp + AW'(1);
      if (tx_load) tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_wr) - CW'(tx_load);
    end

  // Frame assembly from the queue head
  logic [11:0] tx_frame;
  logic [3:0]  tx_len;
  logic [7:0]  tx_word;
  logic        tx_par;

  always_comb begin
    tx_word  = tx_mem[tx_rp];
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    tx_par   = par_odd;
    for (int i = 0; i < 8; i++)
      if (i < int'(dbits)) begin
        tx_frame[i+1] = tx_word[i];
        tx_par        = tx_par ^ tx_word[i];
      end
    if (par_en) tx_frame[dbits + 4'd1] = tx_par;
    tx_len = dbits + 4'd2 + {3'b000, par_en} + {3'b000, two_stop};
  end

  // Transmit shifter
  logic [11:0] tx_sh;
  logic [3:0]  tx_left, tx_ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_ph <= '0;
    end else if (tick) begin
      if (tx_busy) begin
        tx_ph <= tx_ph + 4'd1;
        if (tx_ph == 4'd15) begin
          if (tx_left == 4'd1) tx_busy <= 1'b0;
          else begin
            tx_left <= tx_left - 4'd1;
            tx_sh   <= {1'b1, tx_sh[11:1]};
          end
        end
      end else if (tx_cnt != '0) begin
        tx_busy <= 1'b1; tx_sh <= tx_frame; tx_left <= tx_len; tx_ph <= '0;
      end
    end

  assign txd = ir_mode ? (tx_busy && !tx_sh[0] && tx_ph < 4'd3)
                       : (!tx_busy || tx_sh[0]);

  // Receive decoder
  logic [1:0] rx_sync;
  logic       rx_lvl, rx_busy, rx_samp, rx_seen, rx_pbit, rx_val, rx_end;
  logic [3:0] rx_ph, rx_bit, rx_par_idx, rx_stop_idx;
  logic [7:0] rx_sh, rx_word;
  logic       rx_bad_par, rx_full, rx_wr, rx_rd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= {2{~ir_mode}};
    else        rx_sync <= {rx_sync[0], rxd};

  assign rx_lvl      = ir_mode ? ~rx_sync[1] : rx_sync[1];
  assign rx_par_idx  = dbits + 4'd1;
  assign rx_stop_idx = dbits + 4'd1 + {3'b000, par_en};
  assign rx_val      = ir_mode ? !(rx_seen || !rx_lvl) : rx_samp;
  assign rx_end      = tick && rx_busy && rx_ph == 4'd15 && rx_bit == rx_stop_idx;
  assign rx_word     = rx_sh >> (2'd3 - word_len);
  assign rx_bad_par  = par_en && ((^rx_word ^ par_odd) != rx_pbit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_ph <= '0; rx_bit <= '0; rx_samp <= 1'b1;
      rx_seen <= 1'b0; rx_pbit <= 1'b0; rx_sh <= '0;
    end else if (tick) begin
      if (!rx_busy) begin
        if (!rx_lvl) begin
          rx_busy <= 1'b1; rx_bit <= '0; rx_seen <= 1'b1;
          rx_ph   <= ir_mode ? 4'd9 : 4'd1;
        end
      end else begin
        rx_ph <= rx_ph + 4'd1;
        if (!rx_lvl) rx_seen <= 1'b1;
        if (rx_ph == 4'd7) begin
          rx_samp <= rx_lvl;
          if (!ir_mode && rx_bit == 4'd0 && rx_lvl) rx_busy <= 1'b0;
        end
        if (rx_ph == 4'd15) begin
          rx_seen <= 1'b0;
          rx_bit  <= rx_bit + 4'd1;
          if (rx_bit >= 4'd1 && rx_bit <= dbits) rx_sh <= {rx_val, rx_sh[7:1]};
          if (par_en && rx_bit == rx_par_idx) rx_pbit <= rx_val;
          if (rx_bit == rx_stop_idx) rx_busy <= 1'b0;
        end
      end
    end

  // Receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;

  assign rx_full  = rx_cnt == CW'(DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_wr    = rx_end && !rx_full;
  assign rx_rd    = rx_pop && !rx_empty;
  assign rx_data  = rx_mem[rx_rp];

  always_ff @(posedge clk)
    if (rx_wr) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_wr) rx_wp <= rx_wp + AW'(1);
      if (rx_rd) rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_rd);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_parity <= 1'b0; err_frame <= 1'b0; err_overrun <= 1'b0;
    end else begin
      if (err_clr) begin
        err_parity <= 1'b0; err_frame <= 1'b0; err_overrun <= 1'b0;
      end
      if (rx_end) begin
        if (rx_bad_par) err_parity  <= 1'b1;
        if (!rx_val)    err_frame   <= 1'b1;
        if (rx_full)    err_overrun <= 1'b1;
      end
    end

  assert_tx_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  assert_tx_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_load) |=> tx_full);
  assert_ir_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_mode && $rose(txd)) |-> (tx_busy && tx_ph == 4'd0));
  assert_rx_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  assert_parity_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !err_clr) |=> err_parity);
  assert_frame_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_val) |=> err_frame);
  assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && rx_full) |=> (err_overrun && rx_full));
endmodule

// File: tb/uart_ir_tb.sv
`timescale 1ns/1ps
module uart_ir_tb;
  logic clk = 0, rst_n = 0;
  logic clk_sel = 0, ext_en = 0;
  logic [15:0] divisor = 0;
  logic [1:0] word_len = 2'd3;
  logic two_stop = 0, par_en = 0, par_odd = 0, ir_mode = 0;
  logic tx_push = 0, rx_pop = 0, err_clr = 0;
  logic [7:0] tx_data = 0;
  logic tx_full, rx_empty, txd, err_parity, err_frame, err_overrun;
  logic [7:0] rx_data;
  logic loop_en = 1, bb_line = 1;
  logic rxd;
  assign rxd = loop_en ? txd : bb_line;

  always #2 clk = ~clk;

  uart_ir u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_en(ext_en), .divisor(divisor),
    .word_len(word_len), .two_stop(two_stop), .par_en(par_en), .par_odd(par_odd),
    .ir_mode(ir_mode), .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .txd(txd), .rxd(rxd),
    .err_clr(err_clr), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  int ext_cnt = 0;
  always @(negedge clk) begin
    ext_cnt = (ext_cnt == 2) ? 0 : ext_cnt + 1;
    ext_en <= (ext_cnt == 0);
  end

  // Behavioural reference of prescaler, transmit queue and framer
  int m_pre, m_ph, m_left, m_idx;
  bit m_busy;
  bit m_bits[12];
  logic [7:0] q[$];
  logic [7:0] sent[$];
  bit saw_full;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_ph = 0; m_left = 0; m_idx = 0; m_busy = 0; q.delete();
    end else begin
      bit src, tk, full_pre;
      src = clk_sel ? ext_en : 1'b1;
      tk = src && (m_pre == int'(divisor));
      full_pre = (q.size() == 64);
      if (src) m_pre = tk ? 0 : m_pre + 1;
      if (tk) begin
        if (m_busy) begin
          if (m_ph == 15) begin
            m_ph = 0;
            if (m_left == 1) m_busy = 0;
            else begin m_left--; m_idx++; end
          end else m_ph++;
        end else if (q.size() > 0) begin
          logic [7:0] b;
          int w;
          bit p;
          b = q.pop_front();
          w = 5 + int'(word_len);
          for (int i = 0; i < 12; i++) m_bits[i] = 1;
          m_bits[0] = 0;
          p = par_odd;
          for (int i = 0; i < w; i++) begin m_bits[1+i] = b[i]; p ^= b[i]; end
          if (par_en) m_bits[w+1] = p;
          m_left = w + 2 + int'(par_en) + int'(two_stop);
          sent.push_back(b & 8'((1 << w) - 1));
          m_busy = 1; m_ph = 0; m_idx = 0;
        end
      end
      if (tx_push && !full_pre) q.push_back(tx_data);
    end
  end

  function automatic bit exp_txd();
    if (ir_mode) return m_busy && !m_bits[m_idx] && m_ph < 3;
    return !m_busy || m_bits[m_idx];
  endfunction

  // R1 R2 R3 R5 R6: serial output matches the model on every clock
  always @(negedge clk)
    if (rst_n && !done) chk(txd === exp_txd(), "R1/R2 txd waveform", txd, exp_txd());

  task automatic cfg(input int dv, input int wl, input bit ts, input bit pe,
                     input bit po, input bit ir, input bit cs);
    @(negedge clk);
    rst_n = 0;
    divisor = 16'(dv); word_len = 2'(wl); two_stop = ts; par_en = pe;
    par_odd = po; ir_mode = ir; clk_sel = cs; loop_en = 1; bb_line = 1;
    sent.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_data = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic wait_done();
    while (m_busy || q.size() != 0) @(negedge clk);
    repeat (16 * 3 * (int'(divisor) + 1) * 2) @(negedge clk);
  endtask

  task automatic pop1(output logic [7:0] d);
    d = rx_data;
    rx_pop = 1; @(negedge clk); rx_pop = 0; @(negedge clk);
  endtask

  task automatic drain(input string req, input int max_keep);
    int expn, got;
    logic [7:0] d;
    expn = (sent.size() > max_keep) ? max_keep : sent.size();
    got = 0;
    while (!rx_empty) begin
      pop1(d);
      if (sent.size() > 0) chk(d === sent[0], req, d, sent[0]);
      else chk(0, req, d, 0);
      if (sent.size() > 0) void'(sent.pop_front());
      got++;
    end
    chk(got == expn, {req, " count"}, got, expn);
    sent.delete();
  endtask

  task automatic bb_frame(input bit bits[12], input int n);
    int per;
    per = 16 * (int'(divisor) + 1);
    loop_en = 0;
    for (int i = 0; i < n; i++) begin
      bb_line = bits[i];
      repeat (per) @(negedge clk);
    end
    bb_line = 1;
    repeat (per * 3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit f[12];
    // Reset state
    cfg(0, 3, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(txd === 1'b1, "R6 idle high after reset", txd, 1);
    chk(tx_full === 1'b0, "R4 queue not full after reset", tx_full, 0);
    chk(rx_empty === 1'b1, "R7 rx empty after reset", rx_empty, 1);
    chk({err_parity, err_frame, err_overrun} === 3'b000, "R9 flags clear", {err_parity, err_frame, err_overrun}, 0);

    // 8 data, no parity, one stop, tick every clock
    push(8'hA5); push(8'h3C); push(8'hFF); push(8'h00);
    wait_done();
    drain("R7 8N1 loopback data", 64);
    chk(err_frame === 1'b0, "R10 no frame error on good frames", err_frame, 0);

    // 5 data, even parity, two stops, divisor 2
    cfg(2, 0, 1, 1, 0, 0, 0);
    push(8'h1F); push(8'hEA); push(8'h13);
    wait_done();
    drain("R2 5-bit frames masked", 64);
    chk(err_parity === 1'b0, "R3 even parity accepted", err_parity, 0);

    // 7 data, odd parity, gated source, divisor 1
    cfg(1, 2, 0, 1, 1, 0, 1);
    push(8'h7F); push(8'h80); push(8'h55);
    wait_done();
    drain("R1 gated source 7-bit data", 64);
    chk(err_parity === 1'b0, "R3 odd parity accepted", err_parity, 0);

    // Infrared coding, divisor 1
    cfg(1, 3, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk(txd === 1'b0, "R5 infrared idle low", txd, 0);
    push(8'h00); push(8'hFF); push(8'h96);
    wait_done();
    drain("R8 infrared loopback data", 64);
    chk(err_frame === 1'b0, "R8 infrared stop decoded", err_frame, 0);

    // Burst past the transmit queue, then receive overflow
    cfg(0, 3, 0, 0, 0, 0, 0);
    saw_full = 0;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk); tx_push = 1; tx_data = 8'(i * 7 + 1);
      if (tx_full) saw_full = 1;
    end
    @(negedge clk); tx_push = 0;
    chk(saw_full, "R4 tx_full raised by burst", saw_full, 1);
    wait_done();
    chk(err_overrun === 1'b1, "R11 overrun flagged", err_overrun, 1);
    drain("R11 first 64 bytes kept", 64);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_overrun === 1'b0, "R11 err_clr clears", err_overrun, 0);

    // Wrong parity driven by hand: data 01, even parity should be 1, send 0
    cfg(3, 3, 0, 1, 0, 0, 0);
    f = '{0, 1,0,0,0,0,0,0,0, 0, 1, 1};
    bb_frame(f, 11);
    chk(err_parity === 1'b1, "R9 parity mismatch flagged", err_parity, 1);
    chk(rx_empty === 1'b0, "R9 byte still queued", rx_empty, 0);
    pop1(d);
    chk(d === 8'h01, "R9 queued byte", d, 8'h01);
    repeat (20) @(negedge clk);
    chk(err_parity === 1'b1, "R9 flag sticky", err_parity, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_parity === 1'b0, "R9 cleared", err_parity, 0);

    // Low stop bit: data 5A, no parity
    cfg(3, 3, 0, 0, 0, 0, 0);
    f = '{0, 0,1,0,1,1,0,1,0, 0, 1, 1};
    bb_frame(f, 10);
    chk(err_frame === 1'b1, "R10 bad stop flagged", err_frame, 1);
    chk(err_parity === 1'b0, "R10 no parity flag", err_parity, 0);
    while (!rx_empty) pop1(d);

    // Short low glitch rejected
    cfg(3, 3, 0, 0, 0, 0, 0);
    loop_en = 0; bb_line = 0;
    repeat (12) @(negedge clk);
    bb_line = 1;
    repeat (16 * 4 * 12) @(negedge clk);
    chk(rx_empty === 1'b1, "R12 glitch queues nothing", rx_empty, 1);
    chk({err_parity, err_frame, err_overrun} === 3'b000, "R12 glitch sets no flag",
        {err_parity, err_frame, err_overrun}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule